// File: doc/BRIEF.md
# MDIO Management Slave

This block is the management-side slave of an Ethernet PHY. It watches the MDC clock and the MDIO data line, both brought into a fast system clock through synchronisers. It recognises clause-22 style management frames and replies to reads by driving MDIO through an output enable. It holds a small set of registers:

- a control register that drives the PHY's reset request, loopback, speed, auto-negotiation enable, negotiation restart, duplex and isolate outputs;
- a status register whose link, jabber and remote-fault bits latch events until software reads them;
- a general-purpose vendor configuration word.

The PHY address is taken from strap inputs while reset is held.

Each MDC rising edge, once detected in the system clock domain, counts as one bit time. The slave first hunts for a preamble of at least 32 ones. It then collects the start, opcode, PHY address and register address. For a matching read it snapshots the register, releases the line for one turnaround bit and drives 0 for the next. It then shifts out 16 data bits, most significant first, and releases the line again. For a write it skips the turnaround and shifts in 16 bits. The register is updated on the last of them.

The system clock must run at least four times faster than MDC.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is decoded only when at least 32 consecutive ones on MDIO come before its first start bit (0). A frame that has only 31 leading ones has no effect.
- R2: A frame is: start 0 then 1; opcode (01 = read, 10 = write); 5-bit PHY address; 5-bit register address; 2 turnaround bits; 16 data bits. Every field is sent MSB first. A write whose address matches the strap updates the addressed register. The control register is at address 0, the status register at 1 and the configuration word at 0x10; the configuration word appears on `cfg_word`.
- R3: A read is answered only when its PHY address equals the strapped address. Otherwise `mdio_oe` stays low for the whole frame.
- R4: A write to PHY address 00000 is accepted whatever the strap (broadcast). A read to 00000 is not answered unless the strap is 00000.
- R5: In a matched read, `mdio_oe` is low during the first turnaround bit. During the second turnaround bit the slave drives 0. It then drives the 16 data bits MSB first, each updated after an MDC rising edge, and releases the line on the following bit.
- R6: The PHY address is latched from `strap_addr` while `rst_n` is low. A latched 00000 holds `ctl_isolate` high whatever control bit 10 holds.
- R7: Status bit 2 (link) and status bit 1 (jabber-free) fall when `link_ok` falls or `jabber` rises. They stay low until the status register is read, and after the read they follow the inputs again. The link bit reads 0 on the first read after reset. The full status word is: bits 14..11 = 1, bit 5 = `an_done` AND auto-negotiation enable, bit 4 = remote fault, bit 3 = 1, bit 2 = link, bit 1 = jabber-free, bit 0 = 1, all other bits 0.
- R8: Status bit 4 (remote fault) latches high on a `remote_fault` pulse. It is cleared by a read of the status register.
- R9: Writing control bit 15 as 1 gives a one-cycle `ctl_reset` pulse and restores the control defaults. Bit 15 reads back as 0.
- R10: Control bit 9 (restart negotiation) is set by a write only when the same write sets bit 12 (auto-negotiation enable). It clears when `an_done` is high and it never stays set while auto-negotiation is disabled.
- R11: After reset the control register reads 0x3100: bit 13 speed = 1, bit 12 auto-negotiation enable = 1, bit 8 full duplex = 1, bit 14 loopback = 0, bit 10 isolate = 0. `cfg_word` is 0 and `mdio_oe` is low.
- R12: A read of an unimplemented register address returns 0x0000 with normal turnaround. A write to such an address changes no register.
- R13: A frame with a bad start code or an opcode of 00 or 11 is abandoned. The slave then needs a fresh 32-one preamble before it accepts another frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x MDC |
| rst_n | input | 1 | Synchronous active-low reset; strap is captured while low |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | MDIO line as seen at the pad |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| strap_addr | input | 5 | PHY address strap pins |
| link_ok | input | 1 | Current link-good indication |
| jabber | input | 1 | Jabber detected indication |
| remote_fault | input | 1 | Remote fault event |
| an_done | input | 1 | Auto-negotiation completed |
| ctl_reset | output | 1 | One-cycle soft reset request |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed | output | 1 | Speed select, 1 = fast |
| ctl_an_en | output | 1 | Auto-negotiation enable |
| ctl_an_restart | output | 1 | Restart auto-negotiation request |
| ctl_duplex | output | 1 | Full duplex select |
| ctl_isolate | output | 1 | Isolate from the data interface |
| cfg_word | output | 16 | Vendor configuration register contents |

## Verification
The assertions assume that `rst_n` is held low long enough for the strap to be seen, and that `strap_addr` is stable during that time. They also assume that `an_done` is never high on the cycle a control write sets the restart bit, because a write that lands together with completion would legitimately keep the bit set. The bench follows these assumptions: it lowers `an_done` before every control write. It drives MDC with a period of about 17 system clocks and changes MDIO only while MDC is low. It samples read data late in the high phase of MDC, which is where a station capturing on the falling edge would sample.

// File: rtl/mdio_pkg.sv
// Package: shared constants and state type for the management slave.
// Assumes clause-22 framing: 2 start, 2 opcode, 5 PHY, 5 register bits.
package mdio_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_MIN  = 32;
    localparam int HDR_BITS = 2 + 1 + 1 + 2 * ADDR_W - 1; // bits after first start bit
    localparam logic [1:0] OP_READ  = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;

    typedef enum logic [2:0] {
        S_HUNT,
        S_HDR,
        S_TURN,
        S_WDATA,
        S_RDATA
    } mdio_state_e;
endpackage

// File: rtl/mdio_sync.sv
// Module: brings MDC and MDIO into the system clock domain and flags
// each MDC rising edge. Assumes clk is at least 4x MDC. Both lines
// see the same delay so the sampled bit lines up with the edge flag.
module mdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic mdc_rise,
    output logic mdio_s
);
    logic [STAGES:0]   mdc_pipe;
    logic [STAGES-1:0] dat_pipe;

    // Synchroniser chains; MDC has one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_pipe <= '0;
            dat_pipe <= '1;
        end else begin
            mdc_pipe <= {mdc_pipe[STAGES-1:0], mdc};
            dat_pipe <= {dat_pipe[STAGES-2:0], mdio_in};
        end
    end

    assign mdc_rise = mdc_pipe[STAGES-1] & ~mdc_pipe[STAGES];
    assign mdio_s   = dat_pipe[STAGES-1];
endmodule

// File: rtl/mdio_frame.sv
// Module: frame engine. Hunts for the preamble, collects the header,
// handles turnaround and shifts data in or out one bit per MDC rise.
// Assumes bit_stb pulses once per MDC rising edge with bit_val valid.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [ADDR_W-1:0] my_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int ONES_W = $clog2(PRE_MIN + 1);
    localparam int CNT_W  = $clog2(DATA_W + 1);

    mdio_state_e          state;
    logic [ONES_W-1:0]    ones;
    logic [CNT_W-1:0]     cnt;
    logic [HDR_BITS-1:0]  hdr;
    logic [HDR_BITS-1:0]  hdr_nx;
    logic                 is_read;
    logic [ADDR_W-1:0]    reg_q;
    logic [DATA_W-1:0]    sh;
    logic                 hdr_done, start_ok, rd_hit, wr_hit;
    logic [1:0]           op;
    logic [ADDR_W-1:0]    phy;

    // Header decode on the bit that completes it.
    always_comb begin
        hdr_nx   = {hdr[HDR_BITS-2:0], bit_val};
        start_ok = hdr_nx[HDR_BITS-1];
        op       = hdr_nx[2*ADDR_W +: 2];
        phy      = hdr_nx[ADDR_W +: ADDR_W];
        hdr_done = bit_stb && (state == S_HDR) && (cnt == CNT_W'(HDR_BITS - 1));
        rd_hit   = hdr_done && start_ok && (op == OP_READ) && (phy == my_addr);
        wr_hit   = hdr_done && start_ok && (op == OP_WRITE) &&
                   ((phy == my_addr) || (phy == '0));
    end

    assign rd_en   = rd_hit;
    assign rd_addr = hdr_nx[ADDR_W-1:0];
    assign wr_en   = bit_stb && (state == S_WDATA) && (cnt == CNT_W'(DATA_W - 1));
    assign wr_addr = reg_q;
    assign wr_data = {sh[DATA_W-2:0], bit_val};

    // Frame state machine, advanced once per MDC rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_HUNT;
            ones     <= '0;
            cnt      <= '0;
            hdr      <= '0;
            is_read  <= 1'b0;
            reg_q    <= '0;
            sh       <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
        end else if (bit_stb) begin
            case (state)
                S_HUNT: begin
                    if (bit_val) begin
                        if (ones != ONES_W'(PRE_MIN)) ones <= ones + 1'b1;
                    end else if (ones == ONES_W'(PRE_MIN)) begin
                        state <= S_HDR;
                        cnt   <= '0;
                        ones  <= '0;
                    end else begin
                        ones <= '0;
                    end
                end
                S_HDR: begin
                    hdr <= hdr_nx;
                    cnt <= cnt + 1'b1;
                    if (hdr_done) begin
                        cnt <= '0;
                        if (rd_hit) begin
                            state   <= S_TURN;
                            is_read <= 1'b1;
                            sh      <= rd_data;
                        end else if (wr_hit) begin
                            state   <= S_TURN;
                            is_read <= 1'b0;
                            reg_q   <= hdr_nx[ADDR_W-1:0];
                        end else begin
                            state <= S_HUNT;
                        end
                    end
                end
                S_TURN: begin
                    if (cnt == '0) begin
                        cnt <= 1'b1;
                    end else begin
                        cnt <= '0;
                        if (is_read) begin
                            mdio_oe  <= 1'b1;
                            mdio_out <= 1'b0;
                            state    <= S_RDATA;
                        end else begin
                            state <= S_WDATA;
                        end
                    end
                end
                S_WDATA: begin
                    sh  <= wr_data;
                    cnt <= cnt + 1'b1;
                    if (wr_en) begin
                        cnt   <= '0;
                        state <= S_HUNT;
                    end
                end
                S_RDATA: begin
                    if (cnt == CNT_W'(DATA_W)) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b0;
                        cnt      <= '0;
                        state    <= S_HUNT;
                    end else begin
                        mdio_out <= sh[DATA_W-1];
                        sh       <= {sh[DATA_W-2:0], 1'b0};
                        cnt      <= cnt + 1'b1;
                    end
                end
                default: state <= S_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Module: register file with control, latching status and config word.
// Assumes rd_en pulses once per accepted read, on the snapshot cycle.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_ADDR = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              link_ok,
    input  logic              jabber,
    input  logic              remote_fault,
    input  logic              an_done,
    output logic              ctl_reset,
    output logic              ctl_loopback,
    output logic              ctl_speed,
    output logic              ctl_an_en,
    output logic              ctl_an_restart,
    output logic              ctl_duplex,
    output logic              ctl_iso_bit,
    output logic [DATA_W-1:0] cfg_word
);
    localparam int B_RST = 15, B_LPBK = 14, B_SPD = 13, B_ANE = 12;
    localparam int B_ISO = 10, B_ANR = 9, B_DUP = 8;

    logic wr_ctl, rd_stat;
    logic link_lat, jab_ok_lat, rf_lat;
    logic [DATA_W-1:0] ctl_view, stat_view;

    assign wr_ctl  = wr_en && (wr_addr == REG_CTRL);
    assign rd_stat = rd_en && (rd_addr == REG_STAT);

    // Control register with self-clearing reset and restart bits.
    always_ff @(posedge clk) begin
        if (!rst_n || (wr_ctl && wr_data[B_RST])) begin
            ctl_loopback   <= 1'b0;
            ctl_speed      <= 1'b1;
            ctl_an_en      <= 1'b1;
            ctl_iso_bit    <= 1'b0;
            ctl_an_restart <= 1'b0;
            ctl_duplex     <= 1'b1;
        end else if (wr_ctl) begin
            ctl_loopback   <= wr_data[B_LPBK];
            ctl_speed      <= wr_data[B_SPD];
            ctl_an_en      <= wr_data[B_ANE];
            ctl_iso_bit    <= wr_data[B_ISO];
            ctl_an_restart <= wr_data[B_ANR] & wr_data[B_ANE];
            ctl_duplex     <= wr_data[B_DUP];
        end else if (an_done || !ctl_an_en) begin
            ctl_an_restart <= 1'b0;
        end
    end

    // One-cycle soft reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_reset <= 1'b0;
        else        ctl_reset <= wr_ctl && wr_data[B_RST];
    end

    // Latched status bits, reloaded from the inputs on a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_lat   <= 1'b0;
            jab_ok_lat <= 1'b1;
            rf_lat     <= 1'b0;
        end else if (rd_stat) begin
            link_lat   <= link_ok;
            jab_ok_lat <= ~jabber;
            rf_lat     <= remote_fault;
        end else begin
            link_lat   <= link_lat & link_ok;
            jab_ok_lat <= jab_ok_lat & ~jabber;
            rf_lat     <= rf_lat | remote_fault;
        end
    end

    // Vendor configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            cfg_word <= '0;
        else if (wr_en && wr_addr == CFG_ADDR) cfg_word <= wr_data;
    end

    // Read multiplexer; unknown addresses read as zero.
    always_comb begin
        ctl_view  = '0;
        ctl_view[B_LPBK] = ctl_loopback;
        ctl_view[B_SPD]  = ctl_speed;
        ctl_view[B_ANE]  = ctl_an_en;
        ctl_view[B_ISO]  = ctl_iso_bit;
        ctl_view[B_ANR]  = ctl_an_restart;
        ctl_view[B_DUP]  = ctl_duplex;
        stat_view = {1'b0, 4'b1111, 5'b0, an_done & ctl_an_en, rf_lat,
                     1'b1, link_lat, jab_ok_lat, 1'b1};
        if (rd_addr == REG_CTRL)      rd_data = ctl_view;
        else if (rd_addr == REG_STAT) rd_data = stat_view;
        else if (rd_addr == CFG_ADDR) rd_data = cfg_word;
        else                          rd_data = '0;
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Module: top of the management slave. Latches the strap address in
// reset, joins synchroniser, frame engine and register file, and forces
// isolate when the strap is zero. Assumes clk >= 4x MDC.
module mdio_mgmt_slave
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              link_ok,
    input  logic              jabber,
    input  logic              remote_fault,
    input  logic              an_done,
    output logic              ctl_reset,
    output logic              ctl_loopback,
    output logic              ctl_speed,
    output logic              ctl_an_en,
    output logic              ctl_an_restart,
    output logic              ctl_duplex,
    output logic              ctl_isolate,
    output logic [DATA_W-1:0] cfg_word
);
    logic              bit_stb, bit_val;
    logic              rd_en, wr_en, iso_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr, my_addr;
    logic [DATA_W-1:0] rd_data, wr_data;

    // Strap capture while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) my_addr <= strap_addr;
    end

    assign ctl_isolate = iso_bit | (my_addr == '0);

    mdio_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .mdc_rise(bit_stb), .mdio_s(bit_val)
    );

    mdio_frame u_frame (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .my_addr(my_addr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .link_ok(link_ok), .jabber(jabber),
        .remote_fault(remote_fault), .an_done(an_done),
        .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
        .ctl_speed(ctl_speed), .ctl_an_en(ctl_an_en),
        .ctl_an_restart(ctl_an_restart), .ctl_duplex(ctl_duplex),
        .ctl_iso_bit(iso_bit), .cfg_word(cfg_word)
    );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
// Module: property checker bound to the management slave top.
// Keeps its own copy of the strap so it does not read design state.
module mdio_mgmt_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] strap_addr,
    input logic       mdio_oe,
    input logic       mdio_out,
    input logic       an_done,
    input logic       ctl_reset,
    input logic       ctl_loopback,
    input logic       ctl_speed,
    input logic       ctl_an_en,
    input logic       ctl_an_restart,
    input logic       ctl_duplex,
    input logic       ctl_isolate
);
    logic [4:0] strap_seen;

    // Independent strap capture for the isolate property.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_seen <= strap_addr;
    end

    p_reset_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_speed && ctl_an_en && ctl_duplex && !ctl_loopback && !mdio_oe));

    p_turn_drives_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    p_reset_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> !ctl_reset);

    p_restart_needs_an_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_an_restart |-> ctl_an_en);

    p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_an_restart && an_done) |=> !ctl_an_restart);

    p_zero_strap_isolates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_seen == 5'd0) |-> ctl_isolate);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (.*);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        m_en = 1'b0;
    logic        m_val = 1'b1;
    logic [4:0]  strap_addr = 5'h0B;
    logic        link_ok = 1'b1;
    logic        jabber = 1'b0;
    logic        remote_fault = 1'b0;
    logic        an_done = 1'b0;
    logic        mdio_out, mdio_oe, mdio_line;
    logic        ctl_reset, ctl_loopback, ctl_speed, ctl_an_en;
    logic        ctl_an_restart, ctl_duplex, ctl_isolate;
    logic [15:0] cfg_word;
    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;
    localparam logic [4:0] ME = 5'h0B;

    always #4 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_out : (m_en ? m_val : 1'b1);

    mdio_mgmt_slave dut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_line),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .strap_addr(strap_addr),
        .link_ok(link_ok), .jabber(jabber), .remote_fault(remote_fault),
        .an_done(an_done), .ctl_reset(ctl_reset), .ctl_loopback(ctl_loopback),
        .ctl_speed(ctl_speed), .ctl_an_en(ctl_an_en),
        .ctl_an_restart(ctl_an_restart), .ctl_duplex(ctl_duplex),
        .ctl_isolate(ctl_isolate), .cfg_word(cfg_word)
    );

    always @(negedge clk) if (ctl_reset) rst_pulses++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One MDC period: drive (or release), rise, sample late in high phase.
    task automatic bit_cyc(input logic en, input logic v, output logic line, output logic oe_s);
        @(negedge clk); m_en = en; m_val = v;
        repeat (8) @(negedge clk); mdc = 1'b1;
        repeat (6) @(negedge clk); line = mdio_line; oe_s = mdio_oe;
        repeat (2) @(negedge clk); mdc = 1'b0;
    endtask

    task automatic put(input logic v);
        logic l, o;
        bit_cyc(1'b1, v, l, o);
    endtask

    task automatic preamble(input int n);
        for (int i = 0; i < n; i++) put(1'b1);
    endtask

    task automatic header(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        put(1'b0); put(1'b1);
        put(op[1]); put(op[0]);
        for (int i = 4; i >= 0; i--) put(phy[i]);
        for (int i = 4; i >= 0; i--) put(ra[i]);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] d, input int npre);
        preamble(npre);
        header(2'b10, phy, ra);
        put(1'b1); put(1'b0);
        for (int i = 15; i >= 0; i--) put(d[i]);
        m_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] d,
                           output logic shape_ok, output logic any_oe);
        logic l, o;
        preamble(32);
        header(2'b01, phy, ra);
        shape_ok = 1'b1; any_oe = 1'b0; d = '0;
        bit_cyc(1'b0, 1'b1, l, o);
        any_oe |= o; shape_ok &= !o;
        bit_cyc(1'b0, 1'b1, l, o);
        any_oe |= o; shape_ok &= (o && !l);
        for (int i = 0; i < 16; i++) begin
            bit_cyc(1'b0, 1'b1, l, o);
            any_oe |= o; shape_ok &= o; d = {d[14:0], l};
        end
        bit_cyc(1'b0, 1'b1, l, o);
        shape_ok &= !o;
    endtask

    // Matched read with turnaround shape check (R5) and value check.
    task automatic read_expect(input string req, input logic [4:0] phy,
                               input logic [4:0] ra, input logic [15:0] exp);
        logic [15:0] d; logic s, a;
        do_read(phy, ra, d, s, a);
        chk("R5 turnaround/data shape", {15'd0, s}, 16'd1);
        chk(req, d, exp);
    endtask

    task automatic do_reset(input logic [4:0] strap);
        @(negedge clk); rst_n = 1'b0; strap_addr = strap;
        repeat (5) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_defaults;
        chk("R11 speed/an/duplex", {13'd0, ctl_speed, ctl_an_en, ctl_duplex}, 16'h7);
        chk("R11 loopback/restart/oe", {13'd0, ctl_loopback, ctl_an_restart, mdio_oe}, 16'h0);
        chk("R11 cfg_word", cfg_word, 16'h0000);
        chk("R6 nonzero strap not isolated", {15'd0, ctl_isolate}, 16'h0);
        read_expect("R11 control readback", ME, 5'd0, 16'h3100);
    endtask

    task automatic t_write_read;
        do_write(ME, 5'h10, 16'hA5C3, 32);
        chk("R2 cfg write", cfg_word, 16'hA5C3);
        read_expect("R2 cfg readback", ME, 5'h10, 16'hA5C3);
        do_write(ME, 5'd0, 16'h4400, 32);
        chk("R2 control outputs", {11'd0, ctl_loopback, ctl_speed, ctl_an_en, ctl_duplex, ctl_isolate},
            16'b10001);
        read_expect("R2 control readback", ME, 5'd0, 16'h4400);
    endtask

    task automatic t_preamble;
        do_write(ME, 5'h10, 16'h1234, 31);
        chk("R1 31-one preamble ignored", cfg_word, 16'hA5C3);
        do_write(ME, 5'h10, 16'h1234, 32);
        chk("R1 32-one preamble accepted", cfg_word, 16'h1234);
    endtask

    task automatic t_addr_match;
        logic [15:0] d; logic s, a;
        do_read(5'h0C, 5'h10, d, s, a);
        chk("R3 foreign read not answered", {15'd0, a}, 16'h0);
        do_write(5'h0C, 5'h10, 16'h7777, 32);
        chk("R3 foreign write ignored", cfg_word, 16'h1234);
    endtask

    task automatic t_broadcast;
        logic [15:0] d; logic s, a;
        do_write(5'h00, 5'h10, 16'h0F0F, 32);
        chk("R4 broadcast write", cfg_word, 16'h0F0F);
        do_read(5'h00, 5'h10, d, s, a);
        chk("R4 broadcast read unanswered", {15'd0, a}, 16'h0);
    endtask

    task automatic t_status_latch;
        read_expect("R7 link latched low from reset", ME, 5'd1, 16'h780B);
        read_expect("R7 link good after read", ME, 5'd1, 16'h780F);
        @(negedge clk); link_ok = 1'b0;
        repeat (3) @(negedge clk); link_ok = 1'b1;
        read_expect("R7 link drop held", ME, 5'd1, 16'h780B);
        read_expect("R7 link restored after read", ME, 5'd1, 16'h780F);
        @(negedge clk); jabber = 1'b1;
        repeat (3) @(negedge clk); jabber = 1'b0;
        read_expect("R7 jabber held", ME, 5'd1, 16'h780D);
        read_expect("R7 jabber cleared after read", ME, 5'd1, 16'h780F);
    endtask

    task automatic t_remote_fault;
        @(negedge clk); remote_fault = 1'b1;
        @(negedge clk); remote_fault = 1'b0;
        read_expect("R8 remote fault latched", ME, 5'd1, 16'h781F);
        read_expect("R8 remote fault cleared", ME, 5'd1, 16'h780F);
    endtask

    task automatic t_soft_reset;
        rst_pulses = 0;
        do_write(ME, 5'd0, 16'h8000 | 16'h4400, 32);
        chk("R9 one reset pulse", 16'(rst_pulses), 16'd1);
        chk("R9 defaults restored", {12'd0, ctl_loopback, ctl_speed, ctl_an_en, ctl_duplex}, 16'b0111);
        read_expect("R9 reset bit reads 0", ME, 5'd0, 16'h3100);
    endtask

    task automatic t_an_restart;
        do_write(ME, 5'd0, 16'h1200, 32);
        chk("R10 restart set", {15'd0, ctl_an_restart}, 16'h1);
        read_expect("R10 restart readback", ME, 5'd0, 16'h1200);
        @(negedge clk); an_done = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 restart self-clear", {15'd0, ctl_an_restart}, 16'h0);
        read_expect("R10 an complete in status", ME, 5'd1, 16'h782F);
        @(negedge clk); an_done = 1'b0;
        do_write(ME, 5'd0, 16'h0200, 32);
        chk("R10 restart ignored with AN off", {15'd0, ctl_an_restart}, 16'h0);
        read_expect("R10 readback with AN off", ME, 5'd0, 16'h0000);
        do_write(ME, 5'd0, 16'h3100, 32);
    endtask

    task automatic t_unimpl;
        read_expect("R12 unimplemented reads zero", ME, 5'h07, 16'h0000);
        do_write(ME, 5'h07, 16'hFFFF, 32);
        chk("R12 write ignored cfg", cfg_word, 16'h0F0F);
        read_expect("R12 write ignored control", ME, 5'd0, 16'h3100);
    endtask

    task automatic t_abort;
        preamble(32);
        header(2'b11, ME, 5'h10);
        header(2'b10, ME, 5'h10);
        put(1'b1); put(1'b0);
        for (int i = 15; i >= 0; i--) put(1'b0);
        m_en = 1'b0; repeat (6) @(negedge clk);
        chk("R13 bad opcode then no preamble ignored", cfg_word, 16'h0F0F);
        preamble(32);
        put(1'b0); put(1'b0);
        for (int i = 0; i < 28; i++) put(1'b0);
        do_write(ME, 5'h10, 16'hBEEF, 32);
        chk("R13 new preamble after bad start", cfg_word, 16'hBEEF);
    endtask

    task automatic t_strap_zero;
        do_reset(5'h00);
        chk("R6 zero strap isolates", {15'd0, ctl_isolate}, 16'h1);
        read_expect("R6 iso bit clear, strap zero", 5'h00, 5'd0, 16'h3100);
        chk("R6 still isolated", {15'd0, ctl_isolate}, 16'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(ME);
        t_reset_defaults();
        t_write_read();
        t_preamble();
        t_addr_match();
        t_broadcast();
        do_reset(ME);
        t_status_latch();
        t_remote_fault();
        t_soft_reset();
        t_an_restart();
        do_write(ME, 5'h10, 16'h0F0F, 32);
        t_unimpl();
        t_abort();
        t_strap_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule